// File: doc/BRIEF.md
# UART Receive Interrupt Identification Unit

This block gathers the receive-side interrupt sources of a 16550-style UART and turns them into a 4-bit identification code and a single interrupt request. It watches the fill level of the receive FIFO and its push and pop strobes. It latches the four receive error strobes and compares the FIFO level against a threshold chosen by a 2-bit select. It also runs a character-timeout timer from a bit-time tick.

Software reads the code to learn which source needs service. Reading the line status register clears the latched errors. The data-available source follows the FIFO level on its own. Any FIFO traffic, including a receive buffer read, restarts the timeout.

All pending state is held in registers, so the code and the request reflect the inputs sampled at the previous clock edge.

Top module: `uart_iid_top`

## Requirements
- R1: After reset the code is 0001, the request is low and all latched error flags are zero.
- R2: An error strobe latches its flag into `errFlags` on the next edge, with bit 0 for overrun, bit 1 for parity, bit 2 for framing and bit 3 for break. While any flag is set, the code is 0110.
- R3: A line status read clears all latched flags. An error strobe in the same cycle as the read stays latched.
- R4: With no error latched, the code is 0100 while `fifoCount` is at or above the threshold. `trigSel` codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14.
- R5: The data-available code goes away one cycle after `fifoCount` drops below the threshold, with no register read needed.
- R6: After 40 bit ticks with no FIFO activity while the FIFO is non-empty, the code is 1100, provided neither higher source is active.
- R7: A push, a pop or a receive buffer read clears the timeout source and restarts its tick count from zero.
- R8: While `fifoCount` is zero, the timeout count holds at zero and the timeout source is cleared. Ticks seen while empty do not count.
- R9: Priority order is line status, then data-available, then timeout. A pending timeout hidden by data-available shows again once data-available goes away.
- R10: `irq` is high exactly when bit 0 of the code is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoCount | input | 5 | Receive FIFO fill level |
| fifoPush | input | 1 | Character written into the receive FIFO |
| fifoPop | input | 1 | Character removed from the receive FIFO |
| errOverrun | input | 1 | Overrun error strobe |
| errParity | input | 1 | Parity error strobe |
| errFraming | input | 1 | Framing error strobe |
| errBreak | input | 1 | Break condition strobe |
| trigSel | input | 2 | Receive threshold select |
| bitTick | input | 1 | One pulse per serial bit time |
| lsrRead | input | 1 | Line status register read strobe |
| rbrRead | input | 1 | Receive buffer register read strobe |
| intId | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |
| errFlags | output | 4 | Latched receive error flags |

## Verification
The hardest situation to reach from the ports is a timeout that is pending but hidden behind data-available, and that must show again once the level falls. Reaching it needs 40 quiet ticks on a non-empty FIFO, then a level change without a push or pop strobe. Directed sequences drive exactly 39 and then 40 ticks to probe the timeout boundary, including after ticks that arrive while the FIFO is empty. They also raise and lower the level directly to uncover the hidden timeout. Constrained random traffic keeps pushes and pops rare, so timeouts occur often among errors, reads and threshold changes.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  typedef enum logic [3:0] {
    IID_NONE    = 4'b0001,
    IID_LINE    = 4'b0110,
    IID_DATA    = 4'b0100,
    IID_TIMEOUT = 4'b1100
  } iidCode_e;

  localparam int ERR_W   = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;

  typedef struct packed {
    logic errClear;
    logic timerRestart;
    logic timerHold;
    logic timerStep;
  } iidStrobe_t;

endpackage

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic             rbrRead,
  input  logic             lsrRead,
  input  logic             bitTick,
  input  logic [1:0]       trigSel,
  output iidStrobe_t       strobe,
  output logic [CNT_W-1:0] threshold
);

  logic fifoActive;
  logic fifoEmpty;

  assign fifoActive = fifoPush | fifoPop | rbrRead;
  assign fifoEmpty  = (fifoCount == '0);

  always_comb begin
    strobe.errClear     = lsrRead;
    strobe.timerHold    = fifoEmpty;
    strobe.timerRestart = fifoActive;
    strobe.timerStep    = bitTick & ~fifoEmpty & ~fifoActive;
  end

  always_comb begin
    case (trigSel)
      2'b00:   threshold = CNT_W'(TRIG_L0);
      2'b01:   threshold = CNT_W'(TRIG_L1);
      2'b10:   threshold = CNT_W'(TRIG_L2);
      default: threshold = CNT_W'(TRIG_L3);
    endcase
  end

endmodule

// File: rtl/uart_iid_dpath.sv
module uart_iid_dpath
  import uart_iid_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int TIMEOUT_TICKS = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  iidStrobe_t       strobe,
  input  logic [ERR_W-1:0] errIn,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] threshold,
  output logic [ERR_W-1:0] errFlags,
  output logic             dataPend,
  output logic             timeoutPend
);

  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_TICKS - 1);
  localparam logic [TMR_W-1:0] TMR_FULL = TMR_W'(TIMEOUT_TICKS);

  logic [TMR_W-1:0] idleTicks;

  // One sticky flag per error source; a new strobe beats a clear.
  for (genvar g = 0; g < ERR_W; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rstN)             errFlags[g] <= 1'b0;
      else if (errIn[g])     errFlags[g] <= 1'b1;
      else if (strobe.errClear) errFlags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataPend <= 1'b0;
    else       dataPend <= (fifoCount >= threshold);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleTicks   <= '0;
      timeoutPend <= 1'b0;
    end else if (strobe.timerHold || strobe.timerRestart) begin
      idleTicks   <= '0;
      timeoutPend <= 1'b0;
    end else if (strobe.timerStep && idleTicks != TMR_FULL) begin
      idleTicks <= idleTicks + 1'b1;
      if (idleTicks == TMR_LAST) timeoutPend <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
(
  input  logic [ERR_W-1:0] errFlags,
  input  logic             dataPend,
  input  logic             timeoutPend,
  output logic [3:0]       intId,
  output logic             irq
);

  iidCode_e code;

  always_comb begin
    if (|errFlags)        code = IID_LINE;
    else if (dataPend)    code = IID_DATA;
    else if (timeoutPend) code = IID_TIMEOUT;
    else                  code = IID_NONE;
  end

  assign intId = code;
  assign irq   = (code != IID_NONE);

endmodule

// File: rtl/uart_iid_top.sv
module uart_iid_top
  import uart_iid_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int TIMEOUT_TICKS = 40,
  parameter int TRIG_L0       = 1,
  parameter int TRIG_L1       = 4,
  parameter int TRIG_L2       = 8,
  parameter int TRIG_L3       = 14,
  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic             errOverrun,
  input  logic             errParity,
  input  logic             errFraming,
  input  logic             errBreak,
  input  logic [1:0]       trigSel,
  input  logic             bitTick,
  input  logic             lsrRead,
  input  logic             rbrRead,
  output logic [3:0]       intId,
  output logic             irq,
  output logic [3:0]       errFlags
);

  iidStrobe_t       strobe;
  logic [CNT_W-1:0] threshold;
  logic [ERR_W-1:0] errIn;
  logic             dataPend;
  logic             timeoutPend;

  always_comb begin
    errIn          = '0;
    errIn[ERR_OVR] = errOverrun;
    errIn[ERR_PAR] = errParity;
    errIn[ERR_FRM] = errFraming;
    errIn[ERR_BRK] = errBreak;
  end

  uart_iid_ctrl #(
    .CNT_W(CNT_W), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
    .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3)
  ) u_ctrl (
    .fifoCount(fifoCount), .fifoPush(fifoPush), .fifoPop(fifoPop),
    .rbrRead(rbrRead), .lsrRead(lsrRead), .bitTick(bitTick),
    .trigSel(trigSel), .strobe(strobe), .threshold(threshold)
  );

  uart_iid_dpath #(
    .CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errIn(errIn),
    .fifoCount(fifoCount), .threshold(threshold), .errFlags(errFlags),
    .dataPend(dataPend), .timeoutPend(timeoutPend)
  );

  uart_iid_prio u_prio (
    .errFlags(errFlags), .dataPend(dataPend), .timeoutPend(timeoutPend),
    .intId(intId), .irq(irq)
  );

endmodule

// File: rtl/uart_iid_checker.sv
module uart_iid_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoPush,
  input logic             fifoPop,
  input logic             rbrRead,
  input logic             lsrRead,
  input logic             errOverrun,
  input logic             errParity,
  input logic             errFraming,
  input logic             errBreak,
  input logic [3:0]       intId,
  input logic             irq,
  input logic [3:0]       errFlags
);

  logic anyErr;
  assign anyErr = errOverrun | errParity | errFraming | errBreak;

  assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq == !intId[0]);

  assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    intId == 4'b0001 || intId == 4'b0110 || intId == 4'b0100 || intId == 4'b1100);

  assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags != 4'b0000) |-> (intId == 4'b0110));

  assert_err_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> (errFlags != 4'b0000));

  assert_lsr_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !anyErr) |=> (errFlags == 4'b0000));

  assert_activity_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPush || fifoPop || rbrRead) |=> (intId != 4'b1100));

  assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |=> (intId != 4'b1100));

  assert_empty_nodata_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |=> (intId != 4'b0100));

endmodule

bind uart_iid_top uart_iid_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .fifoPush(fifoPush),
  .fifoPop(fifoPop), .rbrRead(rbrRead), .lsrRead(lsrRead),
  .errOverrun(errOverrun), .errParity(errParity), .errFraming(errFraming),
  .errBreak(errBreak), .intId(intId), .irq(irq), .errFlags(errFlags)
);

// File: tb/uart_iid_top_bench.sv
module uart_iid_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] fifoCount = '0;
  logic       fifoPush = 1'b0, fifoPop = 1'b0;
  logic       errOverrun = 1'b0, errParity = 1'b0, errFraming = 1'b0, errBreak = 1'b0;
  logic [1:0] trigSel = 2'b00;
  logic       bitTick = 1'b0, lsrRead = 1'b0, rbrRead = 1'b0;
  logic [3:0] intId;
  logic       irq;
  logic [3:0] errFlags;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [3:0] mErr = '0;
  bit         mRda = 1'b0;
  bit         mCti = 1'b0;
  int         mTicks = 0;

  always #2 clk = ~clk;

  uart_iid_top u_uart_iid_top (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .fifoPush(fifoPush),
    .fifoPop(fifoPop), .errOverrun(errOverrun), .errParity(errParity),
    .errFraming(errFraming), .errBreak(errBreak), .trigSel(trigSel),
    .bitTick(bitTick), .lsrRead(lsrRead), .rbrRead(rbrRead),
    .intId(intId), .irq(irq), .errFlags(errFlags)
  );

  function automatic int thrOf(logic [1:0] t);
    case (t)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [3:0] expCode(logic [3:0] e, bit rda, bit cti);
    if (e != 4'b0000) return 4'b0110;
    if (rda)          return 4'b0100;
    if (cti)          return 4'b1100;
    return 4'b0001;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Advance one clock: update the reference from the inputs, clock, then compare.
  task automatic step();
    logic [3:0] eIn;
    bit act;
    logic [3:0] e;
    eIn = {errBreak, errFraming, errParity, errOverrun};
    act = fifoPush | fifoPop | rbrRead;
    if (lsrRead) mErr = eIn; else mErr = mErr | eIn;
    mRda = (int'(fifoCount) >= thrOf(trigSel));
    if (fifoCount == 0 || act) begin
      mTicks = 0; mCti = 1'b0;
    end else if (bitTick && mTicks < 40) begin
      mTicks++;
      if (mTicks == 40) mCti = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    fifoPush = 0; fifoPop = 0; rbrRead = 0; lsrRead = 0; bitTick = 0;
    errOverrun = 0; errParity = 0; errFraming = 0; errBreak = 0;
    e = expCode(mErr, mRda, mCti);
    chk("R9 code vs reference", intId, e);
    chk("R10 irq", {3'b000, irq}, {3'b000, (e != 4'b0001)});
    chk("R3 errFlags vs reference", errFlags, mErr);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      step();
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int level;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset code", intId, 4'b0001);
    chk("R1 reset irq", {3'b000, irq}, 4'b0000);
    chk("R1 reset flags", errFlags, 4'b0000);

    // R4 / R5 thresholds
    trigSel = 2'b01; fifoCount = 5'd3; fifoPush = 1; step();
    chk("R4 below threshold 4", intId, 4'b0001);
    fifoCount = 5'd4; fifoPush = 1; step();
    chk("R4 at threshold 4", intId, 4'b0100);
    fifoCount = 5'd3; fifoPop = 1; step();
    chk("R5 drop below threshold", intId, 4'b0001);
    trigSel = 2'b00; fifoCount = 5'd1; fifoPop = 1; step();
    chk("R4 threshold 1", intId, 4'b0100);
    trigSel = 2'b11; fifoCount = 5'd13; fifoPush = 1; step();
    chk("R4 below threshold 14", intId, 4'b0001);
    fifoCount = 5'd14; fifoPush = 1; step();
    chk("R4 at threshold 14", intId, 4'b0100);
    trigSel = 2'b10; fifoCount = 5'd8; fifoPop = 1; step();
    chk("R4 at threshold 8", intId, 4'b0100);

    // R6 / R7 timeout
    trigSel = 2'b11; fifoCount = 5'd3; fifoPop = 1; step();
    ticks(39);
    chk("R6 39 ticks no timeout", intId, 4'b0001);
    ticks(1);
    chk("R6 40 ticks timeout", intId, 4'b1100);
    fifoCount = 5'd4; fifoPush = 1; step();
    chk("R7 push clears timeout", intId, 4'b0001);
    ticks(39);
    chk("R7 restarted count 39", intId, 4'b0001);
    ticks(1);
    chk("R7 restarted count 40", intId, 4'b1100);
    fifoCount = 5'd3; rbrRead = 1; step();
    chk("R7 buffer read clears timeout", intId, 4'b0001);
    ticks(20);
    fifoPush = 1; bitTick = 1; fifoCount = 5'd4; step();
    ticks(39);
    chk("R7 tick with push not counted", intId, 4'b0001);

    // R8 empty hold
    fifoCount = 5'd0; fifoPop = 1; step();
    ticks(60);
    chk("R8 empty no timeout", intId, 4'b0001);
    fifoCount = 5'd2; step();
    ticks(39);
    chk("R8 empty ticks not counted", intId, 4'b0001);
    ticks(1);
    chk("R8 timeout after refill", intId, 4'b1100);
    fifoCount = 5'd0; step();
    chk("R8 empty clears timeout", intId, 4'b0001);

    // R2 / R3 errors
    errParity = 1; step();
    chk("R2 parity flag bit1", errFlags, 4'b0010);
    chk("R2 line code", intId, 4'b0110);
    fifoCount = 5'd14; step();
    chk("R9 line over data", intId, 4'b0110);
    lsrRead = 1; step();
    chk("R3 read clears flags", errFlags, 4'b0000);
    chk("R3 data shows after clear", intId, 4'b0100);
    lsrRead = 1; errBreak = 1; step();
    chk("R3 break kept over read", errFlags, 4'b1000);
    errOverrun = 1; errFraming = 1; step();
    chk("R2 overrun and framing bits", errFlags, 4'b1101);
    lsrRead = 1; step();
    chk("R3 second read clears", errFlags, 4'b0000);

    // R9 hidden timeout
    trigSel = 2'b10; fifoCount = 5'd2; fifoPop = 1; step();
    ticks(40);
    chk("R6 timeout trigger 8", intId, 4'b1100);
    fifoCount = 5'd8; step();
    chk("R9 data over timeout", intId, 4'b0100);
    fifoCount = 5'd2; step();
    chk("R9 hidden timeout returns", intId, 4'b1100);

    // constrained random
    void'($urandom(32'h1A2B3C4D));
    level = 2;
    for (int i = 0; i < 6000; i++) begin
      fifoCount = 5'(level);
      if ($urandom_range(0, 99) < 2 && level < 16) begin fifoPush = 1; level++; end
      else if ($urandom_range(0, 99) < 2 && level > 0) begin
        if ($urandom_range(0, 1) == 1) fifoPop = 1; else rbrRead = 1;
        level--;
      end
      bitTick    = ($urandom_range(0, 1) == 1);
      lsrRead    = ($urandom_range(0, 59) == 0);
      errOverrun = ($urandom_range(0, 299) == 0);
      errParity  = ($urandom_range(0, 299) == 0);
      errFraming = ($urandom_range(0, 299) == 0);
      errBreak   = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 399) == 0) trigSel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 999) == 0) level = 0;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule